// File: doc/BRIEF.md
# Temperature Channel Scan Sequencer

The block walks a fixed scan order over seven temperature channels, number 0 being the on-die sensor and numbers 1 to 6 remote diode inputs. For each channel it issues a one-cycle start request to an external converter, which is modelled here as a handshake. The block then waits until the converter returns a reading with a valid pulse, or until the remote diode on that channel has been reported open for a set number of consecutive clock cycles. A channel that completes normally stores its 8-bit reading and drops its fault flag. A channel found open stores an all-ones reading, sets its fault flag, and is skipped without any further wait.

Every completed channel gives a one-cycle completion strobe together with the channel number. A second strobe marks the completion of the last channel of each full sweep. Two alarm outputs compare every stored reading against two programmable limits. A channel that carries a fault flag is left out of both comparisons, so an open diode never raises an alarm.

Top module: `tsense_scan_seq`

## Requirements
- R1: While `rst_n` is low, all readings read 00h, all fault flags read 0, `conv_start`, `alert` and `overt` are low and `conv_chan` is 0. After release, the first conversion is on channel 0.
- R2: Channels are converted in the order 0,1,...,6, after which the order wraps to 0. `conv_start` is high for exactly one cycle per channel with `conv_chan` giving the channel number. Each new start immediately follows the previous channel's completion.
- R3: A `conv_valid` pulse while a channel waits stores `conv_data` in that channel's 8-bit field of `readings` (channel k at bits 8k+7..8k). In the cycle after that edge, `chan_done` is high for one cycle and `chan_done_id` equals the channel number.
- R4: On a remote channel, holding `diode_open` high for FAULT_CYC consecutive waiting cycles completes the channel. It sets `fault_flags[k]` to 1, stores FFh, and advances to the next channel.
- R5: Fewer than FAULT_CYC consecutive open cycles never complete a channel. A single low cycle of `diode_open` restarts the count.
- R6: Channel 0 ignores `diode_open` entirely, for any duration, and completes only on `conv_valid`.
- R7: A later normal completion on a channel clears that channel's fault flag.
- R8: If `conv_valid` arrives in the same cycle as the FAULT_CYC-th open cycle, the valid result wins: the data is stored and the fault flag is 0.
- R9: `sweep_done` is high for one cycle, together with `chan_done`, exactly when channel 6 completes. It is low at every other completion.
- R10: `alert` is high when some channel without a fault flag holds a reading above `alert_lim`, and `overt` is high when some such channel holds a reading above `overt_lim`. Readings are compared unsigned. Faulted channels never contribute, and completing a channel with a fault never raises either alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| alert_lim | input | 8 | Upper limit for `alert` |
| overt_lim | input | 8 | Upper limit for `overt` |
| conv_valid | input | 1 | Converter result valid pulse |
| conv_data | input | 8 | Converter result |
| diode_open | input | 1 | Open-diode indication for the channel being converted |
| conv_start | output | 1 | One-cycle conversion request |
| conv_chan | output | 3 | Channel being converted |
| chan_done | output | 1 | One-cycle completion strobe |
| chan_done_id | output | 3 | Channel that completed |
| sweep_done | output | 1 | One-cycle end-of-sweep strobe |
| readings | output | 56 | Stored readings, channel k at bits 8k+7..8k |
| fault_flags | output | 7 | Open-diode flag per channel |
| alert | output | 1 | Limit exceeded on a non-faulted channel |
| overt | output | 1 | Higher limit exceeded on a non-faulted channel |

## Verification
Two completion causes can fall in the same cycle: a converter result and the expiry of the open-diode count. The bench provokes this by holding `diode_open` for FAULT_CYC-1 waiting cycles and then raising `conv_valid` in the cycle in which the count would expire. It judges the result by the stored reading, which must be the converter data and not FFh, and by the fault flag, which must stay 0. The end-of-sweep strobe also coincides with a completion strobe; whenever channel 6 finishes, the bench checks that both strobes are high together.

// File: rtl/tss_pkg.sv
package tss_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/tss_fault_timer.sv
module tss_fault_timer #(
  parameter int FAULT_CYC = 800000,
  localparam int CNT_W = $clog2(FAULT_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic open_i,
  output logic hit
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (arm && open_i) cnt_d = cnt_q + 1'b1;
    else               cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign hit = arm && open_i && (cnt_q == CNT_W'(FAULT_CYC - 1));
endmodule

// File: rtl/tss_chan_ctrl.sv
module tss_chan_ctrl
  import tss_pkg::*;
#(
  parameter int N_CH = 7,
  localparam int CW = $clog2(N_CH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          conv_valid,
  input  logic          fault_hit,
  output logic          conv_start,
  output logic [CW-1:0] chan,
  output logic          remote_wait,
  output logic          store_en,
  output logic          store_fault,
  output logic          done_q,
  output logic [CW-1:0] done_id_q,
  output logic          sweep_q
);
  seq_state_e state_q, state_d;
  logic [CW-1:0] chan_q, chan_d;
  logic finish;

  assign finish = (state_q == ST_WAIT) && (conv_valid || fault_hit);

  always_comb begin
    state_d = state_q;
    chan_d  = chan_q;
    case (state_q)
      ST_IDLE:  state_d = ST_START;
      ST_START: state_d = ST_WAIT;
      ST_WAIT: if (finish) begin
        state_d = ST_START;
        chan_d  = (chan_q == CW'(N_CH - 1)) ? '0 : chan_q + 1'b1;
      end
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      chan_q  <= '0;
      done_q  <= 1'b0;
      sweep_q <= 1'b0;
    end else begin
      state_q <= state_d;
      chan_q  <= chan_d;
      done_q  <= finish;
      sweep_q <= finish && (chan_q == CW'(N_CH - 1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      done_id_q <= '0;
    else if (finish) done_id_q <= chan_q;
  end

  assign conv_start  = (state_q == ST_START);
  assign chan        = chan_q;
  assign remote_wait = (state_q == ST_WAIT) && (chan_q != '0);
  assign store_en    = finish;
  assign store_fault = fault_hit && !conv_valid;
endmodule

// File: rtl/tss_result_bank.sv
module tss_result_bank #(
  parameter int N_CH = 7,
  parameter int DW   = 8,
  localparam int CW = $clog2(N_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             store_en,
  input  logic             store_fault,
  input  logic [CW-1:0]    chan,
  input  logic [DW-1:0]    data,
  output logic [N_CH*DW-1:0] readings,
  output logic [N_CH-1:0]  flags
);
  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    logic          hit_en;
    logic [DW-1:0] rd_q, rd_d;
    assign hit_en = store_en && (chan == CW'(k));
    assign rd_d   = store_fault ? {DW{1'b1}} : data;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rd_q <= '0;
      else if (hit_en) rd_q <= rd_d;
    end
    assign readings[k*DW +: DW] = rd_q;

    if (k == 0) begin : g_local
      assign flags[k] = 1'b0;
    end else begin : g_remote
      logic flt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      flt_q <= 1'b0;
        else if (hit_en) flt_q <= store_fault;
      end
      assign flags[k] = flt_q;
    end
  end
endmodule

// File: rtl/tss_alarm.sv
module tss_alarm #(
  parameter int N_CH = 7,
  parameter int DW   = 8
) (
  input  logic [N_CH*DW-1:0] readings,
  input  logic [N_CH-1:0]    flags,
  input  logic [DW-1:0]      alert_lim,
  input  logic [DW-1:0]      overt_lim,
  output logic               alert,
  output logic               overt
);
  logic [N_CH-1:0] over_a, over_o;
  for (genvar k = 0; k < N_CH; k++) begin : g_cmp
    assign over_a[k] = !flags[k] && (readings[k*DW +: DW] > alert_lim);
    assign over_o[k] = !flags[k] && (readings[k*DW +: DW] > overt_lim);
  end
  assign alert = |over_a;
  assign overt = |over_o;
endmodule

// File: rtl/tsense_scan_seq.sv
module tsense_scan_seq #(
  parameter int N_CH      = 7,
  parameter int DW        = 8,
  parameter int FAULT_CYC = 800000,
  localparam int CW = $clog2(N_CH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DW-1:0]      alert_lim,
  input  logic [DW-1:0]      overt_lim,
  input  logic               conv_valid,
  input  logic [DW-1:0]      conv_data,
  input  logic               diode_open,
  output logic               conv_start,
  output logic [CW-1:0]      conv_chan,
  output logic               chan_done,
  output logic [CW-1:0]      chan_done_id,
  output logic               sweep_done,
  output logic [N_CH*DW-1:0] readings,
  output logic [N_CH-1:0]    fault_flags,
  output logic               alert,
  output logic               overt
);
  logic [1:0] rst_pipe;
  logic       rst_int_n;
  logic       remote_wait, fault_hit, store_en, store_fault;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  tss_fault_timer #(.FAULT_CYC(FAULT_CYC)) u_timer (
    .clk(clk), .rst_n(rst_int_n), .arm(remote_wait),
    .open_i(diode_open), .hit(fault_hit)
  );

  tss_chan_ctrl #(.N_CH(N_CH)) u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .conv_valid(conv_valid),
    .fault_hit(fault_hit), .conv_start(conv_start), .chan(conv_chan),
    .remote_wait(remote_wait), .store_en(store_en),
    .store_fault(store_fault), .done_q(chan_done),
    .done_id_q(chan_done_id), .sweep_q(sweep_done)
  );

  tss_result_bank #(.N_CH(N_CH), .DW(DW)) u_bank (
    .clk(clk), .rst_n(rst_int_n), .store_en(store_en),
    .store_fault(store_fault), .chan(conv_chan), .data(conv_data),
    .readings(readings), .flags(fault_flags)
  );

  tss_alarm #(.N_CH(N_CH), .DW(DW)) u_alarm (
    .readings(readings), .flags(fault_flags),
    .alert_lim(alert_lim), .overt_lim(overt_lim),
    .alert(alert), .overt(overt)
  );
endmodule

// File: rtl/tss_chk.sv
module tss_chk #(
  parameter int N_CH = 7,
  localparam int CW = $clog2(N_CH)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            conv_start,
  input logic [CW-1:0]   conv_chan,
  input logic            chan_done,
  input logic [CW-1:0]   chan_done_id,
  input logic            sweep_done,
  input logic [N_CH-1:0] fault_flags,
  input logic            alert,
  input logic            overt
);
  // R2
  start_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R2
  next_channel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chan_done |-> conv_start &&
      conv_chan == ((chan_done_id == CW'(N_CH - 1)) ? CW'(0) : CW'(chan_done_id + 1'b1)));

  // R3
  done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chan_done |=> !chan_done);

  // R9
  sweep_with_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_done |-> chan_done && chan_done_id == CW'(N_CH - 1));

  // R10
  fault_no_alarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_done && fault_flags[chan_done_id]) |-> (!$rose(alert) && !$rose(overt)));
endmodule

bind tsense_scan_seq tss_chk #(.N_CH(N_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_chan(conv_chan),
  .chan_done(chan_done), .chan_done_id(chan_done_id), .sweep_done(sweep_done),
  .fault_flags(fault_flags), .alert(alert), .overt(overt)
);

// File: tb/tb_tsense_scan_seq.sv
module tb_tsense_scan_seq;
  localparam int FC = 6;
  localparam logic [7:0] A_LIM = 8'h50;
  localparam logic [7:0] O_LIM = 8'h70;
  // mode: 0 normal, 1 open fault, 2 local open ignored, 3 valid with expiry, 4 interrupted open
  localparam int NV = 14;
  localparam logic [10:0] VEC [NV] = '{
    {3'd0, 8'h20}, {3'd1, 8'h00}, {3'd0, 8'h55}, {3'd1, 8'h00},
    {3'd0, 8'h10}, {3'd3, 8'h75}, {3'd1, 8'h00},
    {3'd2, 8'h30}, {3'd0, 8'h40}, {3'd0, 8'h48}, {3'd1, 8'h00},
    {3'd4, 8'h12}, {3'd0, 8'h22}, {3'd0, 8'h49}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic [7:0] alert_lim, overt_lim, conv_data;
  logic conv_valid, diode_open;
  logic conv_start, chan_done, sweep_done, alert, overt;
  logic [2:0] conv_chan, chan_done_id;
  logic [55:0] readings;
  logic [6:0] fault_flags;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] m_rd [7];
  logic       m_fl [7];

  always #2.5 clk = ~clk;

  tsense_scan_seq #(.FAULT_CYC(FC)) dut (
    .clk(clk), .rst_n(rst_n), .alert_lim(alert_lim), .overt_lim(overt_lim),
    .conv_valid(conv_valid), .conv_data(conv_data), .diode_open(diode_open),
    .conv_start(conv_start), .conv_chan(conv_chan), .chan_done(chan_done),
    .chan_done_id(chan_done_id), .sweep_done(sweep_done), .readings(readings),
    .fault_flags(fault_flags), .alert(alert), .overt(overt)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic model_alarm(input logic [7:0] lim);
    logic r = 1'b0;
    for (int k = 0; k < 7; k++) if (!m_fl[k] && m_rd[k] > lim) r = 1'b1;
    return r;
  endfunction

  task automatic run_step(input int ch, input logic [2:0] mode, input logic [7:0] d);
    int guard = 0;
    while (conv_start !== 1'b1 && guard < 50) begin @(negedge clk); guard++; end
    check(conv_start === 1'b1 && conv_chan == 3'(ch), "R2 start/order", {conv_start, conv_chan}, {1'b1, 3'(ch)});
    @(negedge clk);
    case (mode)
      3'd0: begin conv_valid = 1; conv_data = d; @(negedge clk); conv_valid = 0; end
      3'd1: begin
        diode_open = 1; repeat (FC - 1) @(negedge clk);
        check(chan_done == 1'b0, "R5 early completion", chan_done, 0);
        @(negedge clk); diode_open = 0;
      end
      3'd2: begin
        diode_open = 1; repeat (2 * FC) @(negedge clk);
        check(chan_done == 1'b0, "R6 local open ignored", chan_done, 0);
        conv_valid = 1; conv_data = d; @(negedge clk); conv_valid = 0; diode_open = 0;
      end
      3'd3: begin
        diode_open = 1; repeat (FC - 1) @(negedge clk);
        conv_valid = 1; conv_data = d; @(negedge clk); conv_valid = 0; diode_open = 0;
      end
      default: begin
        diode_open = 1; repeat (FC - 1) @(negedge clk);
        diode_open = 0; @(negedge clk);
        diode_open = 1; repeat (FC - 1) @(negedge clk);
        check(chan_done == 1'b0, "R5 restart after gap", chan_done, 0);
        diode_open = 0; conv_valid = 1; conv_data = d; @(negedge clk); conv_valid = 0;
      end
    endcase
    m_rd[ch] = (mode == 3'd1) ? 8'hFF : d;
    m_fl[ch] = (mode == 3'd1);
    check(chan_done && chan_done_id == 3'(ch), "R3 done strobe/id", {chan_done, chan_done_id}, {1'b1, 3'(ch)});
    check(readings[ch*8 +: 8] == m_rd[ch], (mode == 3'd1) ? "R4 FFh on fault" : "R3 R8 reading", readings[ch*8 +: 8], m_rd[ch]);
    check(fault_flags[ch] == m_fl[ch], "R4 R7 R8 fault flag", fault_flags[ch], m_fl[ch]);
    check(sweep_done == (ch == 6), "R9 sweep strobe", sweep_done, (ch == 6));
    check(alert == model_alarm(A_LIM), "R10 alert", alert, model_alarm(A_LIM));
    check(overt == model_alarm(O_LIM), "R10 overt", overt, model_alarm(O_LIM));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; conv_valid = 0; diode_open = 0; conv_data = 0;
    alert_lim = A_LIM; overt_lim = O_LIM;
    for (int k = 0; k < 7; k++) begin m_rd[k] = 0; m_fl[k] = 0; end
    repeat (3) @(negedge clk);
    check(readings == 0 && fault_flags == 0, "R1 reset state", {readings, fault_flags}, 0);
    check(!conv_start && conv_chan == 0 && !alert && !overt, "R1 reset outputs", {conv_start, conv_chan, alert, overt}, 0);
    rst_n = 1;

    for (int i = 0; i < NV; i++) run_step(i % 7, VEC[i][10:8], VEC[i][7:0]);

    // R1: reset in mid-sweep, then restart from channel 0
    run_step(0, 3'd0, 8'h66);
    @(negedge clk); @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    check(readings == 0 && fault_flags == 0, "R1 mid-run reset clears", {readings, fault_flags}, 0);
    check(!conv_start && conv_chan == 0 && !alert && !overt, "R1 mid-run reset outputs", {conv_start, conv_chan, alert, overt}, 0);
    for (int k = 0; k < 7; k++) begin m_rd[k] = 0; m_fl[k] = 0; end
    rst_n = 1;
    run_step(0, 3'd0, 8'h71);
    run_step(1, 3'd1, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule